// File: doc/BRIEF.md
# Opcode-Menu SPI Flash Command Sequencer

This block is a host-driven SPI flash master that executes exactly one flash command for each start request. Firmware first loads a set of eight command bytes, together with a 2-bit kind for each command. It also loads two preamble commands, a 24-bit flash address and up to 64 payload bytes, which sit in a word-addressed buffer. A single control write then selects one menu slot, the payload length, an optional preamble, the SPI clock rate and the start bit.

Once started, the sequencer sends the chosen preamble byte, if one was requested, as a chip-select frame of its own. It then opens the main frame and sends the command byte. The three address bytes follow for the address-carrying kinds. Payload bytes come next, either shifted out of the buffer or shifted into it. Completion and error are reported in sticky status bits that are cleared by writing 1. The control state machine has seven states:

- IDLE, with transitions start-accepted→PREFIX (preamble requested) and start-accepted→OPCODE (no preamble).
- PREFIX, which moves byte-done→GAP.
- GAP, which moves gap-expired→OPCODE.
- OPCODE, which moves byte-done→ADDR (address kinds), byte-done→DATA (payload enabled, no address) or byte-done→CLOSE (neither).
- ADDR, which moves third-byte-done→DATA (payload enabled) or third-byte-done→CLOSE.
- DATA, which moves last-byte-done→CLOSE.
- CLOSE, which moves unconditionally→IDLE.

Top module: `spiseq_top`

## Requirements
- R1: After reset the status word (register 0) reads 0, chip select is high and the serial clock is low.
- R2: Command slot i is taken from byte (i mod 4) of register 4 for i<4 and of register 5 for i>=4. Its kind is bits 2i+1:2i of register 3, coded 0 read without address, 1 write without address, 2 read with address, 3 write with address. The slot number is control bits 14:12.
- R3: The low 24 bits of register 1 are sent as three bytes, most significant first, right after the command byte, and only for kinds 2 and 3.
- R4: Payload bytes move only when control bit 15 is set. Their number is control bits 21:16 plus one (1 to 64).
- R5: Buffer byte n lives in register 16+n/4 at bits 8*(n mod 4). Write kinds send buffer bytes 0..N-1 in order. Read kinds store received bytes at the same positions and leave the other bytes untouched.
- R6: Control bit 9 sends a preamble byte in its own frame before the main frame. Control bit 10 picks register 2 bits 15:8 when set and bits 7:0 when clear. Chip select stays high for at least one SPI clock period between the two frames.
- R7: The SPI port works in mode 0, MSB first. The serial clock is low whenever chip select is high.
- R8: Control bits 25:24 (sel) set the SPI clock high and low phases to 2^sel system cycles each. With an 80 MHz system clock, sel=1 gives 20 MHz.
- R9: Status bit 0 (done) sets when a command ends. Writing 1 to bit 0 or bit 1 clears that bit. A control write may clear status and start (bit 8) in one access, and a write without bit 8 starts nothing.
- R10: A start while a command runs sends nothing new and sets both error (bit 1) and done, visible the next cycle. The running command completes normally.
- R11: Status bit 2 reads 1 from the cycle after an accepted start until the command has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 5 | Register word address |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data (combinational) |
| spi_sclk | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to flash |
| spi_miso | input | 1 | SPI data from flash |

## Verification
Status effects of a register write (done and error on a rejected start, busy on an accepted start, write-1 clears) show up one cycle after the write edge. The bench therefore reads status at the falling edge after the write, or polls until busy drops. Serial results depend on the clock divider, so they are not checked at fixed cycles. A behavioural flash model samples the port at every falling system-clock edge and records each byte at its SPI rising edge, along with the frame boundaries, the chip-select gap and the clock-high widths in system cycles. These recordings are compared against expected byte lists once the command has finished. Read payloads are checked by reading the buffer back after done.

// File: rtl/spiseq_pkg.sv
package spiseq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PREFIX,
        SQ_GAP,
        SQ_OPCODE,
        SQ_ADDR,
        SQ_DATA,
        SQ_CLOSE
    } sq_state_t;

    // control / status bit positions (register 0)
    localparam int CTL_DONE   = 0;
    localparam int CTL_ERR    = 1;
    localparam int CTL_BUSY   = 2;
    localparam int CTL_GO     = 8;
    localparam int CTL_ATOM   = 9;
    localparam int CTL_PSEL   = 10;
    localparam int CTL_PTR_LO = 12;
    localparam int CTL_DEN    = 15;
    localparam int CTL_CNT_LO = 16;
    localparam int CTL_CLK_LO = 24;

    typedef struct packed {
        logic [2:0] ptr;
        logic       atomic;
        logic       psel;
        logic       den;
        logic [5:0] cnt;
        logic [1:0] clk_sel;
    } sq_cmd_t;

endpackage

// File: rtl/spiseq_regs.sv
module spiseq_regs
    import spiseq_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int BUF_WORDS = 16,
    parameter int BUF_BASE  = 16,
    parameter int IDX_W     = $clog2(BUF_WORDS * 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              go_o,
    output sq_cmd_t           cmd_o,
    output logic [23:0]       flash_addr_o,
    output logic [15:0]       prefix_o,
    output logic [15:0]       types_o,
    output logic [63:0]       menu_o,
    output logic              err_o,
    input  logic              busy_i,
    input  logic              set_done_i,
    input  logic              set_err_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [7:0]        rd_byte_o,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [7:0]        wr_byte_i
);

    localparam int WORD_W = $clog2(BUF_WORDS);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_FADR = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_PFX  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_TYP  = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_MLO  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_MHI  = ADDR_W'(5);

    logic [23:0]       faddr_q;
    logic [15:0]       pfx_q;
    logic [15:0]       typ_q;
    logic [63:0]       menu_q;
    logic              done_q, err_q;
    logic [31:0]       buf_q [BUF_WORDS];
    logic              in_buf;
    logic [ADDR_W-1:0] buf_off;
    logic [WORD_W-1:0] buf_word;
    logic              ctrl_wr;
    logic [31:0]       rd_word;

    assign in_buf   = (int'(host_addr) >= BUF_BASE) && (int'(host_addr) < BUF_BASE + BUF_WORDS);
    assign buf_off  = host_addr - ADDR_W'(BUF_BASE);
    assign buf_word = buf_off[WORD_W-1:0];
    assign ctrl_wr  = host_we && (host_addr == A_CTRL);

    assign go_o          = ctrl_wr && host_wdata[CTL_GO];
    assign cmd_o.ptr     = host_wdata[CTL_PTR_LO +: 3];
    assign cmd_o.atomic  = host_wdata[CTL_ATOM];
    assign cmd_o.psel    = host_wdata[CTL_PSEL];
    assign cmd_o.den     = host_wdata[CTL_DEN];
    assign cmd_o.cnt     = host_wdata[CTL_CNT_LO +: 6];
    assign cmd_o.clk_sel = host_wdata[CTL_CLK_LO +: 2];

    assign flash_addr_o = faddr_q;
    assign prefix_o     = pfx_q;
    assign types_o      = typ_q;
    assign menu_o       = menu_q;
    assign err_o        = err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            faddr_q <= '0;
            pfx_q   <= '0;
            typ_q   <= '0;
            menu_q  <= '0;
        end else if (host_we) begin
            unique case (host_addr)
                A_FADR:  faddr_q       <= host_wdata[23:0];
                A_PFX:   pfx_q         <= host_wdata[15:0];
                A_TYP:   typ_q         <= host_wdata[15:0];
                A_MLO:   menu_q[31:0]  <= host_wdata;
                A_MHI:   menu_q[63:32] <= host_wdata;
                default: ;
            endcase
        end
    end

    // sticky status: set wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (ctrl_wr && host_wdata[CTL_DONE]) done_q <= 1'b0;
            if (ctrl_wr && host_wdata[CTL_ERR])  err_q  <= 1'b0;
            if (set_done_i) done_q <= 1'b1;
            if (set_err_i)  err_q  <= 1'b1;
        end
    end

    // payload buffer: sequencer byte write lands after a host word write
    always_ff @(posedge clk) begin
        if (host_we && in_buf)
            buf_q[buf_word] <= host_wdata;
        if (wr_en_i)
            buf_q[wr_idx_i[IDX_W-1:2]][8*wr_idx_i[1:0] +: 8] <= wr_byte_i;
    end

    assign rd_word   = buf_q[rd_idx_i[IDX_W-1:2]];
    assign rd_byte_o = rd_word[8*rd_idx_i[1:0] +: 8];

    always_comb begin
        host_rdata = '0;
        if (in_buf) begin
            host_rdata = buf_q[buf_word];
        end else begin
            case (host_addr)
                A_CTRL:  host_rdata = {29'b0, busy_i, err_q, done_q};
                A_FADR:  host_rdata = {8'b0, faddr_q};
                A_PFX:   host_rdata = {16'b0, pfx_q};
                A_TYP:   host_rdata = {16'b0, typ_q};
                A_MLO:   host_rdata = menu_q[31:0];
                A_MHI:   host_rdata = menu_q[63:32];
                default: host_rdata = '0;
            endcase
        end
    end

    // R9
    done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_done_i |=> done_q);

endmodule

// File: rtl/spiseq_shifter.sv
module spiseq_shifter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [7:0]       tx_i,
    input  logic [CNT_W-1:0] half_m1_i,
    input  logic             miso_i,
    output logic             sclk_o,
    output logic             mosi_o,
    output logic [7:0]       rx_o,
    output logic             done_o,
    output logic             busy_o
);

    logic [7:0]       sh_q;
    logic [2:0]       bit_q;
    logic [CNT_W-1:0] cnt_q;

    assign mosi_o = sh_q[7];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            bit_q  <= '0;
            cnt_q  <= '0;
            sclk_o <= 1'b0;
            rx_o   <= '0;
            done_o <= 1'b0;
            busy_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                sh_q   <= tx_i;
                bit_q  <= '0;
                cnt_q  <= '0;
                sclk_o <= 1'b0;
                busy_o <= 1'b1;
            end else if (busy_o) begin
                if (cnt_q == half_m1_i) begin
                    cnt_q <= '0;
                    if (!sclk_o) begin
                        sclk_o <= 1'b1;
                        rx_o   <= {rx_o[6:0], miso_i};
                    end else begin
                        sclk_o <= 1'b0;
                        if (bit_q == 3'd7) begin
                            busy_o <= 1'b0;
                            done_o <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 3'd1;
                            sh_q  <= {sh_q[6:0], 1'b0};
                        end
                    end
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    // R7
    byte_ends_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !sclk_o);

endmodule

// File: rtl/spiseq_fsm.sv
module spiseq_fsm
    import spiseq_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int GAP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  sq_cmd_t          cmd_i,
    input  logic [23:0]      flash_addr_i,
    input  logic [15:0]      prefix_i,
    input  logic [15:0]      types_i,
    input  logic [63:0]      menu_i,
    input  logic             sh_done_i,
    input  logic             sh_busy_i,
    input  logic [7:0]       sh_rx_i,
    output logic             sh_start_o,
    output logic [7:0]       sh_tx_o,
    output logic [1:0]       clk_sel_o,
    output logic             cs_n_o,
    output logic             busy_o,
    output logic             set_done_o,
    output logic             set_err_o,
    output logic [IDX_W-1:0] rd_idx_o,
    input  logic [7:0]       rd_byte_i,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [7:0]       wr_byte_o
);

    sq_state_t        state_q, state_d;
    sq_cmd_t          cmd_q;
    logic [7:0]       opc_q, pfx_q;
    logic [1:0]       typ_q;
    logic [23:0]      addr_q;
    logic [GAP_W-1:0] gap_q;
    logic [IDX_W-1:0] idx_q;
    logic             last_data, reject;
    logic [7:0]       new_opc, new_pfx, data_tx;
    logic [1:0]       new_typ;

    function automatic logic [7:0] addr_byte(input logic [23:0] a, input logic [IDX_W-1:0] k);
        case (k[1:0])
            2'd0:    return a[23:16];
            2'd1:    return a[15:8];
            default: return a[7:0];
        endcase
    endfunction

    assign new_opc   = menu_i[8*cmd_i.ptr +: 8];
    assign new_typ   = types_i[2*cmd_i.ptr +: 2];
    assign new_pfx   = cmd_i.psel ? prefix_i[15:8] : prefix_i[7:0];
    assign last_data = (idx_q == IDX_W'(cmd_q.cnt));
    assign clk_sel_o = cmd_q.clk_sel;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:   if (go_i) state_d = cmd_i.atomic ? SQ_PREFIX : SQ_OPCODE;
            SQ_PREFIX: if (sh_done_i) state_d = SQ_GAP;
            SQ_GAP:    if (gap_q == '0) state_d = SQ_OPCODE;
            SQ_OPCODE: if (sh_done_i)
                           state_d = typ_q[1] ? SQ_ADDR : (cmd_q.den ? SQ_DATA : SQ_CLOSE);
            SQ_ADDR:   if (sh_done_i && idx_q == IDX_W'(2))
                           state_d = cmd_q.den ? SQ_DATA : SQ_CLOSE;
            SQ_DATA:   if (sh_done_i && last_data) state_d = SQ_CLOSE;
            SQ_CLOSE:  state_d = SQ_IDLE;
            default:   state_d = SQ_IDLE;
        endcase
    end

    // decoded outputs
    always_comb begin
        busy_o     = (state_q != SQ_IDLE);
        reject     = go_i && busy_o;
        set_err_o  = reject;
        set_done_o = reject || (state_q == SQ_CLOSE);
        rd_idx_o   = (state_q == SQ_DATA) ? idx_q + IDX_W'(1) : '0;
        data_tx    = typ_q[0] ? rd_byte_i : 8'h00;
        wr_en_o    = (state_q == SQ_DATA) && sh_done_i && !typ_q[0];
        wr_idx_o   = idx_q;
        wr_byte_o  = sh_rx_i;
    end

    // datapath and registered bus controls
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q      <= '0;
            opc_q      <= '0;
            pfx_q      <= '0;
            typ_q      <= '0;
            addr_q     <= '0;
            gap_q      <= '0;
            idx_q      <= '0;
            cs_n_o     <= 1'b1;
            sh_start_o <= 1'b0;
            sh_tx_o    <= '0;
        end else begin
            sh_start_o <= 1'b0;
            unique case (state_q)
                SQ_IDLE: if (go_i) begin
                    cmd_q      <= cmd_i;
                    opc_q      <= new_opc;
                    pfx_q      <= new_pfx;
                    typ_q      <= new_typ;
                    addr_q     <= flash_addr_i;
                    cs_n_o     <= 1'b0;
                    sh_start_o <= 1'b1;
                    sh_tx_o    <= cmd_i.atomic ? new_pfx : new_opc;
                end
                SQ_PREFIX: if (sh_done_i) begin
                    cs_n_o <= 1'b1;
                    gap_q  <= GAP_W'((2 << cmd_q.clk_sel) - 1);
                end
                SQ_GAP: begin
                    if (gap_q == '0) begin
                        cs_n_o     <= 1'b0;
                        sh_start_o <= 1'b1;
                        sh_tx_o    <= opc_q;
                    end else begin
                        gap_q <= gap_q - GAP_W'(1);
                    end
                end
                SQ_OPCODE: if (sh_done_i) begin
                    idx_q <= '0;
                    if (typ_q[1]) begin
                        sh_start_o <= 1'b1;
                        sh_tx_o    <= addr_q[23:16];
                    end else if (cmd_q.den) begin
                        sh_start_o <= 1'b1;
                        sh_tx_o    <= data_tx;
                    end else begin
                        cs_n_o <= 1'b1;
                    end
                end
                SQ_ADDR: if (sh_done_i) begin
                    if (idx_q == IDX_W'(2)) begin
                        idx_q <= '0;
                        if (cmd_q.den) begin
                            sh_start_o <= 1'b1;
                            sh_tx_o    <= data_tx;
                        end else begin
                            cs_n_o <= 1'b1;
                        end
                    end else begin
                        idx_q      <= idx_q + IDX_W'(1);
                        sh_start_o <= 1'b1;
                        sh_tx_o    <= addr_byte(addr_q, idx_q + IDX_W'(1));
                    end
                end
                SQ_DATA: if (sh_done_i) begin
                    if (last_data) begin
                        cs_n_o <= 1'b1;
                    end else begin
                        idx_q      <= idx_q + IDX_W'(1);
                        sh_start_o <= 1'b1;
                        sh_tx_o    <= data_tx;
                    end
                end
                SQ_CLOSE: ;
                default: ;
            endcase
        end
    end

    // R6
    frame_ends_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> !sh_busy_i);

    // R7
    launch_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start_o |-> !sh_busy_i);

    // R1
    idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_IDLE) && !sh_busy_i |-> cs_n_o);

endmodule

// File: rtl/spiseq_top.sv
module spiseq_top
    import spiseq_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int BUF_WORDS = 16,
    parameter int BUF_BASE  = 16,
    parameter int CNT_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    localparam int IDX_W = $clog2(BUF_WORDS * 4);
    localparam int GAP_W = CNT_W + 1;

    logic             go, busy, set_done, set_err, err_flag;
    sq_cmd_t          cmd;
    logic [23:0]      faddr;
    logic [15:0]      prefix, types;
    logic [63:0]      menu;
    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [7:0]       rd_byte, wr_byte, sh_tx, sh_rx;
    logic             wr_en, sh_start, sh_done, sh_busy;
    logic [1:0]       clk_sel;
    logic [CNT_W-1:0] half_m1;

    assign half_m1 = CNT_W'((1 << clk_sel) - 1);

    spiseq_regs #(
        .ADDR_W(ADDR_W), .BUF_WORDS(BUF_WORDS), .BUF_BASE(BUF_BASE), .IDX_W(IDX_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .go_o(go), .cmd_o(cmd), .flash_addr_o(faddr), .prefix_o(prefix), .types_o(types),
        .menu_o(menu), .err_o(err_flag), .busy_i(busy), .set_done_i(set_done), .set_err_i(set_err),
        .rd_idx_i(rd_idx), .rd_byte_o(rd_byte), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_byte_i(wr_byte)
    );

    spiseq_fsm #(.IDX_W(IDX_W), .GAP_W(GAP_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .go_i(go), .cmd_i(cmd), .flash_addr_i(faddr), .prefix_i(prefix), .types_i(types),
        .menu_i(menu), .sh_done_i(sh_done), .sh_busy_i(sh_busy), .sh_rx_i(sh_rx),
        .sh_start_o(sh_start), .sh_tx_o(sh_tx), .clk_sel_o(clk_sel), .cs_n_o(spi_cs_n),
        .busy_o(busy), .set_done_o(set_done), .set_err_o(set_err),
        .rd_idx_o(rd_idx), .rd_byte_i(rd_byte), .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_byte_o(wr_byte)
    );

    spiseq_shifter #(.CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .start_i(sh_start), .tx_i(sh_tx), .half_m1_i(half_m1), .miso_i(spi_miso),
        .sclk_o(spi_sclk), .mosi_o(spi_mosi), .rx_o(sh_rx), .done_o(sh_done), .busy_o(sh_busy)
    );

    // R7
    clock_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R10
    busy_start_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && busy) |=> err_flag);

endmodule

// File: tb/tb_spiseq_top.sv
module tb_spiseq_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        spi_sclk, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int nchk = 0;
    int nerr = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spiseq_top dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // ---------------- behavioural flash model ----------------
    logic [7:0] cap[$];
    int         flen[$];
    logic [7:0] expq[$];
    int         fexp[$];
    int bitc = 0, bidx = 0, gaprun = 0, last_gap = 0, hirun = 0, last_hi = 0, m0_bad = 0;
    logic [7:0] shb = '0, rbyte;
    logic prev_cs = 1'b1, prev_sclk = 1'b0;

    function automatic logic [7:0] rep(input int k);
        return 8'hC3 ^ 8'(k * 37);
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            bitc = 0; bidx = 0; prev_cs = 1'b1; prev_sclk = 1'b0;
        end else begin
            if (spi_cs_n && spi_sclk) m0_bad++;
            if (spi_sclk) hirun++;
            else begin
                if (prev_sclk) last_hi = hirun;
                hirun = 0;
            end
            if (spi_cs_n) begin
                if (!prev_cs) flen.push_back(bidx);
                bidx = 0; bitc = 0; gaprun++;
            end else begin
                if (prev_cs) begin last_gap = gaprun; gaprun = 0; end
                if (spi_sclk && !prev_sclk) begin
                    shb = {shb[6:0], spi_mosi};
                    bitc++;
                    if (bitc == 8) begin cap.push_back(shb); bidx++; bitc = 0; end
                end
            end
            rbyte = rep(bidx);
            spi_miso = rbyte[7 - bitc];
            prev_cs = spi_cs_n;
            prev_sclk = spi_sclk;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = 5'(a); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        host_addr = 5'(a);
        #1 d = host_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] s;
        do begin
            @(negedge clk);
            rd(0, s);
        end while (s[2] || !s[0]);
        repeat (2) @(negedge clk);
    endtask

    task automatic clr();
        cap.delete(); flen.delete(); expq.delete(); fexp.delete();
    endtask

    task automatic check_frames(input string req);
        chk(flen.size() == fexp.size(), req, "frame count", 64'(flen.size()), 64'(fexp.size()));
        for (int i = 0; i < fexp.size() && i < flen.size(); i++)
            chk(flen[i] == fexp[i], req, "frame length", 64'(flen[i]), 64'(fexp[i]));
        chk(cap.size() == expq.size(), req, "byte count", 64'(cap.size()), 64'(expq.size()));
        for (int i = 0; i < expq.size() && i < cap.size(); i++)
            chk(cap[i] == expq[i], req, $sformatf("byte %0d", i), 64'(cap[i]), 64'(expq[i]));
    endtask

    function automatic logic [31:0] mk(input int ptr, input bit den, input int n,
                                      input bit atom, input bit psel, input int sel);
        logic [31:0] w;
        w = 32'h0000_0103;
        w |= 32'(atom) << 9;
        w |= 32'(psel) << 10;
        w |= 32'(ptr & 7) << 12;
        w |= 32'(den) << 15;
        w |= 32'((n - 1) & 63) << 16;
        w |= 32'(sel & 3) << 24;
        return w;
    endfunction

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] s, v;
        logic [1:0] ty [8];
        logic [15:0] tyw;
        ty = '{2'd3, 2'd2, 2'd3, 2'd0, 2'd2, 2'd1, 2'd0, 2'd1};
        tyw = '0;
        for (int i = 0; i < 8; i++) tyw |= 16'(ty[i]) << (2 * i);

        repeat (3) @(negedge clk);
        // R1 reset state
        rd(0, s);
        chk(s == 0, "R1", "status after reset", 64'(s), 0);
        chk(spi_cs_n == 1'b1, "R1", "cs_n after reset", 64'(spi_cs_n), 1);
        chk(spi_sclk == 1'b0, "R1", "sclk after reset", 64'(spi_sclk), 0);
        rst_n = 1'b1;

        wr(2, 32'h0000_9A06);            // prefix1=06, prefix2=9A
        wr(3, {16'h0, tyw});
        wr(4, 32'h0520_0302);            // slots 0..3 = 02 03 20 05
        wr(5, 32'hC79F_01AB);            // slots 4..7 = AB 01 9F C7

        // R2 opcode-only, slot 7; R11 busy
        clr();
        wr(0, mk(7, 0, 1, 0, 0, 0));
        rd(0, s);
        chk(s[2] == 1'b1, "R11", "busy after start", 64'(s[2]), 1);
        wait_done();
        fexp.push_back(1); expq.push_back(8'hC7);
        check_frames("R2");
        chk(last_hi == 1, "R8", "sclk high width sel0", 64'(last_hi), 1);
        rd(0, s);
        chk(s[2:0] == 3'b001, "R9", "status after finish", 64'(s[2:0]), 1);

        // R3 R4 R5 read with address, 4 bytes, slot 4
        clr();
        wr(1, 32'hFF12_3456);
        wr(0, mk(4, 1, 4, 0, 0, 0));
        wait_done();
        fexp.push_back(8);
        expq = '{8'hAB, 8'h12, 8'h34, 8'h56, 8'h00, 8'h00, 8'h00, 8'h00};
        check_frames("R3");
        rd(16, v);
        chk(v == {rep(7), rep(6), rep(5), rep(4)}, "R5", "read payload word0", 64'(v),
            64'({rep(7), rep(6), rep(5), rep(4)}));

        // R6 atomic with prefix 2, write with address, 5 bytes, slot 0
        clr();
        wr(16, 32'h4433_2211);
        wr(17, 32'h0000_0055);
        wr(1, 32'h0000_1020);
        wr(0, mk(0, 1, 5, 1, 1, 0));
        wait_done();
        fexp = '{1, 9};
        expq = '{8'h9A, 8'h02, 8'h00, 8'h10, 8'h20, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
        check_frames("R6");
        chk(last_gap >= 2, "R6", "cs high gap", 64'(last_gap), 2);

        // R6 prefix 1, write without address, 1 byte, slot 5
        clr();
        wr(0, mk(5, 1, 1, 1, 0, 0));
        wait_done();
        fexp = '{1, 2};
        expq = '{8'h06, 8'h01, 8'h11};
        check_frames("R6");

        // R5 read without address, 3 bytes, slot 3; byte 3 untouched
        clr();
        wr(0, mk(3, 1, 3, 0, 0, 0));
        wait_done();
        fexp = '{4};
        expq = '{8'h05, 8'h00, 8'h00, 8'h00};
        check_frames("R5");
        rd(16, v);
        chk(v == {8'h44, rep(3), rep(2), rep(1)}, "R5", "partial word fill", 64'(v),
            64'({8'h44, rep(3), rep(2), rep(1)}));

        // R4 full 64-byte write, slot 2
        clr();
        for (int w = 0; w < 16; w++)
            wr(16 + w, {8'(4 * w + 3), 8'(4 * w + 2), 8'(4 * w + 1), 8'(4 * w)});
        wr(1, 32'h0000_ABCD);
        wr(0, mk(2, 1, 64, 0, 0, 0));
        wait_done();
        fexp = '{68};
        expq = '{8'h20, 8'h00, 8'hAB, 8'hCD};
        for (int n = 0; n < 64; n++) expq.push_back(8'(n));
        check_frames("R4");

        // R10 start while busy
        clr();
        wr(1, 32'h0);
        wr(0, mk(2, 1, 8, 0, 0, 0));
        repeat (5) @(negedge clk);
        wr(0, 32'h0000_0100 | (32'd5 << 12));
        rd(0, s);
        chk(s[2:0] == 3'b111, "R10", "status after rejected start", 64'(s[2:0]), 7);
        do begin @(negedge clk); rd(0, s); end while (s[2]);
        repeat (2) @(negedge clk);
        fexp = '{12};
        expq = '{8'h20, 8'h00, 8'h00, 8'h00};
        for (int n = 0; n < 8; n++) expq.push_back(8'(n));
        check_frames("R10");

        // R9 write-1-to-clear, no start without go bit
        clr();
        wr(0, 32'h0000_0002);
        rd(0, s);
        chk(s[2:0] == 3'b001, "R9", "clear error only", 64'(s[2:0]), 1);
        wr(0, 32'h0000_0001);
        rd(0, s);
        chk(s[2:0] == 3'b000, "R9", "clear done", 64'(s[2:0]), 0);
        repeat (4) @(negedge clk);
        chk(flen.size() == 0, "R9", "frames without go", 64'(flen.size()), 0);

        // R8 clock select 1, slot 6 no payload
        clr();
        wr(0, mk(6, 0, 1, 0, 0, 1));
        wait_done();
        fexp = '{1};
        expq = '{8'h9F};
        check_frames("R8");
        chk(last_hi == 2, "R8", "sclk high width sel1", 64'(last_hi), 2);
        rd(0, s);
        chk(s[2:0] == 3'b001, "R9", "status after clear+start", 64'(s[2:0]), 1);

        // R7 mode 0 idle clock across the whole run
        chk(m0_bad == 0, "R7", "sclk high with cs_n high", 64'(m0_bad), 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule